// File: doc/BRIEF.md
# Branch Decode and PC Update

This block owns the program counter of a 64-bit core with a fixed 32-bit instruction width. On each cycle where the fetch stage marks an instruction word valid, the block classifies that word within the branch, exception and system class. It evaluates branch conditions against the NZCV flags and reads one source register through a combinational register-file read port. It then loads the program counter with the next address: a branch target, the following word, or the faulting address. Register index 31 always reads as zero when it is the source.

A call-type branch also produces a link write of the return address into register 30. Encodings that are reserved, or that name features this block does not carry out, produce a one-cycle undefined-instruction pulse. The pulse comes with the address of the offending word. Unsupported encodings are additionally marked with a second flag. Hints and memory barriers retire as no-ops. All results are registered, so they appear one clock after the instruction is presented.

Top module: `br_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `pc_q` loads the parameter `RESET_VEC` and `lr_we`, `undef_o`, `unsup_o`, `lr_wdata` and `fault_pc` load zero.
- R2: In a cycle with `insn_valid` low, `pc_q` keeps its value and `lr_we`, `undef_o` and `unsup_o` are low in the following cycle, whatever `insn` holds.
- R3: Bits 31:25 equal to 0x0a, 0x0b, 0x4a or 0x4b select a direct jump to P + 4*sext(insn[25:0]), where P is the current `pc_q`. When bit 31 is 1 the block also pulses `lr_we` with `lr_wdata` = P + 4 (destined for register 30).
- R4: Bits 31:25 equal to 0x2a select a conditional branch with offset field insn[23:5]. If bit 4 or bit 24 is set it is undefined. Otherwise, if the condition in insn[3:0] holds, the next PC is P + 4*sext(insn[23:5]), else P + 4. Codes 0xE and 0xF always hold.
- R5: With `nzcv` = {N,Z,C,V} (N at bit 3, V at bit 0), even codes and their odd complements hold as follows. 0x0: Z. 0x2: C. 0x4: N. 0x6: V. 0x8: C and not Z. 0xA: N equal to V. 0xC: not Z and N equal to V. Odd codes 0x1 to 0xD are the negation of the code below them.
- R6: Bits 31:25 equal to 0x1b or 0x5b select a bit test of register insn[4:0] at position {insn[31], insn[23:19]}. Bit 24 = 0 branches when that bit is 0, and bit 24 = 1 branches when it is 1. The taken target is P + 4*sext(insn[18:5]); otherwise the next PC is P + 4.
- R7: Bits 31:25 equal to 0x6b select a register branch. It is undefined unless insn[20:16] = 0x1F and insn[15:10] and insn[4:0] are zero. Opcode insn[24:21] equal to 0 or 2 jumps to register insn[9:5]. Opcode 1 jumps there and pulses `lr_we` with P + 4.
- R8: A register branch with opcode 4 or 5 is unsupported (`undef_o` and `unsup_o`) when insn[9:5] = 31, and plainly undefined otherwise. Every other opcode is undefined.
- R9: Source register 31 reads as zero for bit tests and register branches, regardless of `rf_rdata`.
- R10: With bits 31:22 = 0x354 and op0 = insn[20:19] = 0, the word is undefined unless insn[21] = 0 and insn[4:0] = 31. CRn = insn[15:12] = 2 (hint) with op1 = insn[18:16] = 3 retires as a no-op (P + 4) for any selector. CRn = 3 (barrier) with op1 = 3 retires as a no-op for op2 = insn[7:5] of 4, 5 or 6. A hint or barrier with op1 other than 3, a barrier with op2 other than 2, 4, 5 or 6, and any CRn other than 2, 3 or 4 are undefined.
- R11: The following are unsupported and raise both `undef_o` and `unsup_o`: compare-and-branch (0x1a, 0x5a), exception generation (0x6a with bit 24 clear), system words with op0 not 0, CRn = 4 state writes and barrier op2 = 2.
- R12: On an undefined or unsupported word, `undef_o` pulses for one cycle, `fault_pc` equals the address of that word and `pc_q` stays at that address. No link write happens.
- R13: Any value of bits 31:25 not listed in R3, R4, R6, R7, R10 or R11 is undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn | input | 32 | Instruction word at address `pc_q` |
| nzcv | input | 4 | Condition flags {N,Z,C,V} |
| rf_raddr | output | 5 | Register-file read index (combinational from `insn`) |
| rf_rdata | input | 64 | Register-file read data for `rf_raddr` |
| pc_q | output | 64 | Current program counter |
| lr_we | output | 1 | One-cycle link write to register 30 |
| lr_wdata | output | 64 | Return address for the link write |
| undef_o | output | 1 | One-cycle undefined-instruction pulse |
| unsup_o | output | 1 | The fault is an unsupported (not reserved) encoding |
| fault_pc | output | 64 | Address of the most recent faulting word |

## Verification
On every cycle the embedded properties confirm the following: an idle cycle leaves the PC untouched and raises no pulse; a fault holds the PC at the reported address and never coincides with a link write; an unsupported flag never appears without the undefined pulse; and every link value is the prior PC plus four. Other behaviour can only be shown by the bench's scenarios, run against a behavioural model of the whole instruction class. This covers the target arithmetic with negative and positive offsets, each condition code under chosen flags, both bit-test polarities at the low, middle and top positions, the zero reading of register 31, and the reserved-field, hint and barrier filtering.

// File: rtl/br_pkg.sv
package br_pkg;
    localparam int unsigned PC_W     = 64;
    localparam int unsigned INSN_W   = 32;
    localparam int unsigned RIDX_W   = 5;
    localparam int unsigned FLAG_W   = 4;
    localparam int unsigned STEP     = 4;
    localparam logic [RIDX_W-1:0] ZERO_IDX = RIDX_W'(31);

    typedef logic [PC_W-1:0]   addr_t;
    typedef logic [INSN_W-1:0] word_t;

    typedef enum logic [2:0] {
        GRP_JUMP, GRP_CMPB, GRP_TBIT, GRP_COND,
        GRP_SYS,  GRP_EXC,  GRP_REG,  GRP_NONE
    } grp_e;

    typedef struct packed {
        logic  fault;
        logic  unsup;
        logic  link;
        addr_t target;
    } br_res_t;

    function automatic grp_e grp_of(input logic [6:0] op7, input logic b24);
        grp_e g;
        case (op7)
            7'h0a, 7'h0b, 7'h4a, 7'h4b: g = GRP_JUMP;
            7'h1a, 7'h5a:               g = GRP_CMPB;
            7'h1b, 7'h5b:               g = GRP_TBIT;
            7'h2a:                      g = GRP_COND;
            7'h6a:                      g = b24 ? GRP_SYS : GRP_EXC;
            7'h6b:                      g = GRP_REG;
            default:                    g = GRP_NONE;
        endcase
        return g;
    endfunction
endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
    import br_pkg::*;
(
    input  logic [3:0]        cond,
    input  logic [FLAG_W-1:0] nzcv,
    output logic              pass
);
    logic fn, fz, fc, fv, base;

    assign fn = nzcv[3];
    assign fz = nzcv[2];
    assign fc = nzcv[1];
    assign fv = nzcv[0];

    always_comb begin
        case (cond[3:1])
            3'd0:    base = fz;
            3'd1:    base = fc;
            3'd2:    base = fn;
            3'd3:    base = fv;
            3'd4:    base = fc & ~fz;
            3'd5:    base = (fn == fv);
            3'd6:    base = ~fz & (fn == fv);
            default: base = 1'b1;
        endcase
    end

    // codes 0xE and 0xF both always pass; the low bit inverts only real conditions
    assign pass = (cond[3:1] == 3'd7) ? 1'b1 : (base ^ cond[0]);
endmodule

// File: rtl/br_decode.sv
module br_decode
    import br_pkg::*;
(
    input  word_t             insn,
    input  addr_t             pc,
    input  logic [FLAG_W-1:0] nzcv,
    output logic [RIDX_W-1:0] rf_raddr,
    input  addr_t             rf_rdata,
    output br_res_t           res
);
    grp_e  grp;
    addr_t seq_pc, src_val;
    addr_t off_jump, off_cond, off_tbit;
    logic  cond_ok, tbit_val;
    logic [5:0] tbit_pos;

    assign grp    = grp_of(insn[31:25], insn[24]);
    assign seq_pc = pc + addr_t'(STEP);

    // bit tests read Rt, register branches read Rn
    assign rf_raddr = (grp == GRP_TBIT) ? insn[4:0] : insn[9:5];
    assign src_val  = (rf_raddr == ZERO_IDX) ? '0 : rf_rdata;

    assign off_jump = {{(PC_W-28){insn[25]}}, insn[25:0], 2'b00};
    assign off_cond = {{(PC_W-21){insn[23]}}, insn[23:5], 2'b00};
    assign off_tbit = {{(PC_W-16){insn[18]}}, insn[18:5], 2'b00};

    assign tbit_pos = {insn[31], insn[23:19]};
    assign tbit_val = src_val[tbit_pos];

    br_cond_eval u_cond (
        .cond (insn[3:0]),
        .nzcv (nzcv),
        .pass (cond_ok)
    );

    always_comb begin
        res        = '0;
        res.target = seq_pc;
        case (grp)
            GRP_JUMP: begin
                res.target = pc + off_jump;
                res.link   = insn[31];
            end
            GRP_TBIT: begin
                if (tbit_val == insn[24]) res.target = pc + off_tbit;
            end
            GRP_COND: begin
                if (insn[4] | insn[24]) res.fault = 1'b1;
                else if (cond_ok)       res.target = pc + off_cond;
            end
            GRP_REG: begin
                if (insn[20:16] != 5'h1f || insn[15:10] != 6'd0 || insn[4:0] != 5'd0) begin
                    res.fault = 1'b1;
                end else begin
                    case (insn[24:21])
                        4'd0, 4'd2: res.target = src_val;
                        4'd1: begin
                            res.target = src_val;
                            res.link   = 1'b1;
                        end
                        4'd4, 4'd5: begin
                            res.fault = 1'b1;
                            res.unsup = (insn[9:5] == ZERO_IDX);
                        end
                        default: res.fault = 1'b1;
                    endcase
                end
            end
            GRP_SYS: begin
                if (insn[20:19] != 2'd0) begin
                    res.fault = 1'b1;
                    res.unsup = 1'b1;
                end else if (insn[21] || insn[4:0] != ZERO_IDX) begin
                    res.fault = 1'b1;
                end else begin
                    case (insn[15:12])
                        4'd2: res.fault = (insn[18:16] != 3'd3);
                        4'd3: begin
                            if (insn[18:16] != 3'd3) begin
                                res.fault = 1'b1;
                            end else begin
                                case (insn[7:5])
                                    3'd4, 3'd5, 3'd6: res.fault = 1'b0;
                                    3'd2: begin
                                        res.fault = 1'b1;
                                        res.unsup = 1'b1;
                                    end
                                    default: res.fault = 1'b1;
                                endcase
                            end
                        end
                        4'd4: begin
                            res.fault = 1'b1;
                            res.unsup = 1'b1;
                        end
                        default: res.fault = 1'b1;
                    endcase
                end
            end
            GRP_CMPB, GRP_EXC: begin
                res.fault = 1'b1;
                res.unsup = 1'b1;
            end
            default: res.fault = 1'b1;
        endcase
    end

    // R12: a faulting word never requests a link write
    always_comb begin
        a_r12_no_link_on_fault: assert (!(res.fault && res.link));
    end

    // R11: unsupported is a sub-case of a fault
    always_comb begin
        a_r11_unsup_is_fault: assert (!res.unsup || res.fault);
    end
endmodule

// File: rtl/br_unit.sv
module br_unit
    import br_pkg::*;
#(
    parameter logic [63:0] RESET_VEC = 64'h0000_0000_0000_1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        insn_valid,
    input  logic [31:0] insn,
    input  logic [3:0]  nzcv,
    output logic [4:0]  rf_raddr,
    input  logic [63:0] rf_rdata,
    output logic [63:0] pc_q,
    output logic        lr_we,
    output logic [63:0] lr_wdata,
    output logic        undef_o,
    output logic        unsup_o,
    output logic [63:0] fault_pc
);
    br_res_t dec;

    br_decode u_dec (
        .insn     (insn),
        .pc       (pc_q),
        .nzcv     (nzcv),
        .rf_raddr (rf_raddr),
        .rf_rdata (rf_rdata),
        .res      (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= RESET_VEC;
            lr_we    <= 1'b0;
            lr_wdata <= '0;
            undef_o  <= 1'b0;
            unsup_o  <= 1'b0;
            fault_pc <= '0;
        end else begin
            lr_we   <= 1'b0;
            undef_o <= 1'b0;
            unsup_o <= 1'b0;
            if (insn_valid) begin
                if (dec.fault) begin
                    undef_o  <= 1'b1;
                    unsup_o  <= dec.unsup;
                    fault_pc <= pc_q;
                end else begin
                    pc_q <= dec.target;
                    if (dec.link) begin
                        lr_we    <= 1'b1;
                        lr_wdata <= pc_q + addr_t'(STEP);
                    end
                end
            end
        end
    end

    a_r2_idle_holds_pc: assert property (@(posedge clk) disable iff (rst)
        !insn_valid |=> $stable(pc_q));

    a_r2_idle_no_pulse: assert property (@(posedge clk) disable iff (rst)
        !insn_valid |=> (!undef_o && !lr_we && !unsup_o));

    a_r12_pc_at_fault: assert property (@(posedge clk) disable iff (rst)
        undef_o |-> (pc_q == fault_pc));

    a_r12_fault_no_link: assert property (@(posedge clk) disable iff (rst)
        undef_o |-> !lr_we);

    a_r11_unsup_with_undef: assert property (@(posedge clk) disable iff (rst)
        unsup_o |-> undef_o);

    a_r3_link_value: assert property (@(posedge clk) disable iff (rst)
        lr_we |-> (lr_wdata == $past(pc_q) + 64'd4));
endmodule

// File: tb/br_unit_tb_top.sv
module br_unit_tb_top;
    localparam int PERIOD = 10;
    localparam logic [63:0] RV = 64'h0000_0000_0000_1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        insn_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [3:0]  nzcv = '0;
    logic [4:0]  rf_raddr;
    logic [63:0] rf_rdata;
    logic [63:0] pc_q, lr_wdata, fault_pc;
    logic        lr_we, undef_o, unsup_o;

    logic [63:0] rf [32];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    logic [63:0] m_pc;

    always #(PERIOD/2) clk = ~clk;
    assign rf_rdata = rf[rf_raddr];

    br_unit #(.RESET_VEC(RV)) dut_i (
        .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn(insn), .nzcv(nzcv),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .pc_q(pc_q), .lr_we(lr_we),
        .lr_wdata(lr_wdata), .undef_o(undef_o), .unsup_o(unsup_o), .fault_pc(fault_pc)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] soff(input logic [25:0] raw, input int bits);
        logic signed [63:0] t;
        t = $signed({38'b0, raw} << (64 - bits));
        t = t >>> (64 - bits);
        return t <<< 2;
    endfunction

    function automatic bit holds(input logic [3:0] c, input logic [3:0] f);
        bit n, z, cy, v;
        n = f[3]; z = f[2]; cy = f[1]; v = f[0];
        case (c)
            4'h0: return z;
            4'h1: return !z;
            4'h2: return cy;
            4'h3: return !cy;
            4'h4: return n;
            4'h5: return !n;
            4'h6: return v;
            4'h7: return !v;
            4'h8: return cy && !z;
            4'h9: return !cy || z;
            4'hA: return n == v;
            4'hB: return n != v;
            4'hC: return !z && (n == v);
            4'hD: return z || (n != v);
            default: return 1'b1;
        endcase
    endfunction

    task automatic ref_step(input logic [31:0] w, input logic [63:0] p, input logic [3:0] f,
                            output logic [63:0] np, output logic lw, output logic [63:0] ld,
                            output logic ud, output logic us);
        logic [6:0]  op;
        logic [63:0] v;
        int idx;
        op = w[31:25];
        np = p + 64'd4; lw = 0; ld = '0; ud = 0; us = 0;
        if (op == 7'h0a || op == 7'h0b || op == 7'h4a || op == 7'h4b) begin
            np = p + soff(w[25:0], 26);
            if (w[31]) begin lw = 1; ld = p + 64'd4; end
        end else if (op == 7'h1a || op == 7'h5a) begin
            ud = 1; us = 1;
        end else if (op == 7'h1b || op == 7'h5b) begin
            idx = int'(w[4:0]);
            v = (idx == 31) ? 64'd0 : rf[idx];
            if (v[{w[31], w[23:19]}] == w[24]) np = p + soff({12'b0, w[18:5]}, 14);
        end else if (op == 7'h2a) begin
            if (w[4] || w[24]) ud = 1;
            else if (holds(w[3:0], f)) np = p + soff({7'b0, w[23:5]}, 19);
        end else if (op == 7'h6a) begin
            if (!w[24]) begin ud = 1; us = 1; end
            else if (w[20:19] != 0) begin ud = 1; us = 1; end
            else if (w[21] || w[4:0] != 5'd31) ud = 1;
            else if (w[15:12] == 4'd2) ud = (w[18:16] != 3'd3);
            else if (w[15:12] == 4'd3) begin
                if (w[18:16] != 3'd3) ud = 1;
                else if (w[7:5] >= 3'd4 && w[7:5] <= 3'd6) ud = 0;
                else if (w[7:5] == 3'd2) begin ud = 1; us = 1; end
                else ud = 1;
            end else if (w[15:12] == 4'd4) begin ud = 1; us = 1; end
            else ud = 1;
        end else if (op == 7'h6b) begin
            idx = int'(w[9:5]);
            v = (idx == 31) ? 64'd0 : rf[idx];
            if (w[20:16] != 5'h1f || w[15:10] != 0 || w[4:0] != 0) ud = 1;
            else if (w[24:21] == 4'd0 || w[24:21] == 4'd2) np = v;
            else if (w[24:21] == 4'd1) begin np = v; lw = 1; ld = p + 64'd4; end
            else if (w[24:21] == 4'd4 || w[24:21] == 4'd5) begin ud = 1; us = (idx == 31); end
            else ud = 1;
        end else begin
            ud = 1;
        end
        if (ud) np = p;
    endtask

    task automatic apply(input string req, input bit vld, input logic [31:0] w, input logic [3:0] f);
        logic [63:0] np, ld, p0;
        logic lw, ud, us;
        @(negedge clk);
        insn_valid = vld; insn = w; nzcv = f;
        p0 = m_pc;
        if (vld) ref_step(w, p0, f, np, lw, ld, ud, us);
        else begin np = p0; lw = 0; ld = '0; ud = 0; us = 0; end
        @(posedge clk);
        #(PERIOD/4);
        chk(req, "pc_q", pc_q, np);
        chk(req, "undef_o", {63'b0, undef_o}, {63'b0, ud});
        chk(req, "unsup_o", {63'b0, unsup_o}, {63'b0, us});
        chk(req, "lr_we", {63'b0, lr_we}, {63'b0, lw});
        if (lw) chk(req, "lr_wdata", lr_wdata, ld);
        if (ud) chk(req, "fault_pc", fault_pc, p0);
        m_pc = np;
    endtask

    function automatic logic [31:0] e_jump(input bit lnk, input logic [25:0] o);
        return {lnk, 5'b00101, o};
    endfunction
    function automatic logic [31:0] e_cond(input logic [18:0] o, input logic [3:0] c);
        return {7'b0101010, 1'b0, o, 1'b0, c};
    endfunction
    function automatic logic [31:0] e_tbit(input bit b5, input bit pol, input logic [4:0] b40,
                                           input logic [13:0] o, input logic [4:0] rt);
        return {b5, 6'b011011, pol, b40, o, rt};
    endfunction
    function automatic logic [31:0] e_reg(input logic [3:0] opc, input logic [4:0] o2,
                                          input logic [5:0] o3, input logic [4:0] rn, input logic [4:0] o4);
        return {7'b1101011, opc, o2, o3, rn, o4};
    endfunction
    function automatic logic [31:0] e_sys(input bit l, input logic [1:0] o0, input logic [2:0] o1,
                                          input logic [3:0] crn, input logic [3:0] crm,
                                          input logic [2:0] o2, input logic [4:0] rt);
        return {10'b1101010100, l, o0, o1, crn, crm, o2, rt};
    endfunction

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) rf[i] = 64'h1111_0000_0000_0000 + 64'(i * 64'h100);
        rf[5]  = 64'h0000_0000_0000_2000;
        rf[7]  = 64'h8000_0000_0000_0010;
        rf[30] = 64'h0000_0000_0000_3004;
        rf[31] = 64'hFFFF_FFFF_FFFF_FFFF;

        repeat (3) @(posedge clk);
        #(PERIOD/4);
        // R1 reset state
        chk("R1", "pc_q", pc_q, RV);
        chk("R1", "undef_o", {63'b0, undef_o}, 64'd0);
        chk("R1", "lr_we", {63'b0, lr_we}, 64'd0);
        chk("R1", "fault_pc", fault_pc, 64'd0);
        chk("R1", "lr_wdata", lr_wdata, 64'd0);
        @(negedge clk); rst = 1'b0;
        m_pc = RV;

        // R2 idle cycles, garbage on the word
        apply("R2", 0, 32'h0000_0000, 4'h0);
        apply("R2", 0, e_jump(1, 26'd5), 4'hF);

        // R3 direct jumps
        apply("R3", 1, e_jump(0, 26'd8), 4'h0);
        apply("R3", 1, e_jump(1, 26'h3FFFFFD), 4'h0);
        apply("R3", 1, e_jump(1, 26'd1), 4'h0);

        // R4 / R5 conditional branches
        apply("R4", 1, e_cond(19'd4, 4'h0), 4'b0100);
        apply("R4", 1, e_cond(19'd4, 4'h0), 4'b0000);
        apply("R5", 1, e_cond(19'h7FFFE, 4'h1), 4'b0000);
        apply("R5", 1, e_cond(19'd3, 4'h8), 4'b0010);
        apply("R5", 1, e_cond(19'd3, 4'h9), 4'b0110);
        apply("R5", 1, e_cond(19'd3, 4'hA), 4'b1001);
        apply("R5", 1, e_cond(19'd3, 4'hB), 4'b1001);
        apply("R5", 1, e_cond(19'd3, 4'hC), 4'b0000);
        apply("R5", 1, e_cond(19'd3, 4'hD), 4'b1000);
        apply("R5", 1, e_cond(19'd2, 4'h4), 4'b1000);
        apply("R5", 1, e_cond(19'd2, 4'h7), 4'b0001);
        apply("R5", 1, e_cond(19'd2, 4'h3), 4'b0010);
        apply("R4", 1, e_cond(19'd6, 4'hE), 4'b0000);
        apply("R4", 1, e_cond(19'd6, 4'hF), 4'b0000);
        apply("R4", 1, e_cond(19'd6, 4'h0) | 32'h10, 4'b0100);
        apply("R4", 1, e_cond(19'd6, 4'h0) | 32'h0100_0000, 4'b0100);

        // R6 bit tests on r7 (bits 63 and 4 set)
        apply("R6", 1, e_tbit(0, 0, 5'd4, 14'd5, 5'd7), 4'h0);
        apply("R6", 1, e_tbit(0, 1, 5'd4, 14'd5, 5'd7), 4'h0);
        apply("R6", 1, e_tbit(1, 1, 5'd31, 14'h3FFC, 5'd7), 4'h0);
        apply("R6", 1, e_tbit(0, 0, 5'd3, 14'd2, 5'd7), 4'h0);
        apply("R6", 1, e_tbit(1, 0, 5'd0, 14'd2, 5'd7), 4'h0);
        // R9 zero register as test source
        apply("R9", 1, e_tbit(0, 0, 5'd0, 14'd3, 5'd31), 4'h0);
        apply("R9", 1, e_tbit(1, 1, 5'd31, 14'd3, 5'd31), 4'h0);

        // R7 register branches
        apply("R7", 1, e_reg(4'd0, 5'h1f, 6'd0, 5'd5, 5'd0), 4'h0);
        apply("R7", 1, e_reg(4'd1, 5'h1f, 6'd0, 5'd5, 5'd0), 4'h0);
        apply("R7", 1, e_reg(4'd2, 5'h1f, 6'd0, 5'd30, 5'd0), 4'h0);
        apply("R9", 1, e_reg(4'd0, 5'h1f, 6'd0, 5'd31, 5'd0), 4'h0);
        apply("R7", 1, e_jump(0, 26'd64), 4'h0);
        apply("R7", 1, e_reg(4'd0, 5'h1e, 6'd0, 5'd5, 5'd0), 4'h0);
        apply("R7", 1, e_reg(4'd0, 5'h1f, 6'd1, 5'd5, 5'd0), 4'h0);
        apply("R7", 1, e_reg(4'd0, 5'h1f, 6'd0, 5'd5, 5'd1), 4'h0);
        // R8 return-type opcodes
        apply("R8", 1, e_reg(4'd4, 5'h1f, 6'd0, 5'd31, 5'd0), 4'h0);
        apply("R8", 1, e_reg(4'd5, 5'h1f, 6'd0, 5'd31, 5'd0), 4'h0);
        apply("R8", 1, e_reg(4'd4, 5'h1f, 6'd0, 5'd3, 5'd0), 4'h0);
        apply("R8", 1, e_reg(4'd3, 5'h1f, 6'd0, 5'd5, 5'd0), 4'h0);

        // R10 hints and barriers
        apply("R10", 1, e_sys(0, 2'd0, 3'd3, 4'd2, 4'd0, 3'd0, 5'd31), 4'h0);
        apply("R10", 1, e_sys(0, 2'd0, 3'd3, 4'd2, 4'd0, 3'd3, 5'd31), 4'h0);
        apply("R10", 1, e_sys(0, 2'd0, 3'd3, 4'd2, 4'd5, 3'd7, 5'd31), 4'h0);
        apply("R10", 1, e_sys(0, 2'd0, 3'd2, 4'd2, 4'd0, 3'd0, 5'd31), 4'h0);
        apply("R10", 1, e_sys(0, 2'd0, 3'd3, 4'd3, 4'd15, 3'd5, 5'd31), 4'h0);
        apply("R10", 1, e_sys(0, 2'd0, 3'd3, 4'd3, 4'd15, 3'd6, 5'd31), 4'h0);
        apply("R10", 1, e_sys(0, 2'd0, 3'd3, 4'd3, 4'd15, 3'd0, 5'd31), 4'h0);
        apply("R10", 1, e_sys(0, 2'd0, 3'd1, 4'd3, 4'd15, 3'd4, 5'd31), 4'h0);
        apply("R10", 1, e_sys(1, 2'd0, 3'd3, 4'd2, 4'd0, 3'd0, 5'd31), 4'h0);
        apply("R10", 1, e_sys(0, 2'd0, 3'd3, 4'd2, 4'd0, 3'd0, 5'd3), 4'h0);
        apply("R10", 1, e_sys(0, 2'd0, 3'd3, 4'd7, 4'd0, 3'd0, 5'd31), 4'h0);

        // R11 unsupported classes
        apply("R11", 1, e_sys(0, 2'd0, 3'd3, 4'd3, 4'd15, 3'd2, 5'd31), 4'h0);
        apply("R11", 1, e_sys(0, 2'd0, 3'd3, 4'd4, 4'd0, 3'd5, 5'd31), 4'h0);
        apply("R11", 1, e_sys(1, 2'd2, 3'd3, 4'd0, 4'd0, 3'd0, 5'd1), 4'h0);
        apply("R11", 1, e_sys(0, 2'd1, 3'd0, 4'd7, 4'd5, 3'd1, 5'd2), 4'h0);
        apply("R11", 1, 32'hD400_0001, 4'h0);
        apply("R11", 1, {7'b0011010, 25'h0}, 4'h0);
        apply("R11", 1, {7'b1011010, 25'h12}, 4'h0);

        // R12 / R13 undefined groups; PC holds
        apply("R13", 1, 32'h0000_0000, 4'h0);
        apply("R13", 1, 32'hFFFF_FFFF, 4'h0);
        apply("R12", 1, e_jump(0, 26'd2), 4'h0);
        apply("R2", 0, 32'hFFFF_FFFF, 4'h0);
        apply("R12", 1, e_sys(0, 2'd0, 3'd3, 4'd2, 4'd0, 3'd0, 5'd31), 4'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule